// File: doc/BRIEF.md
# Startup Output Short-Detection Sequencer

This block gates the first switching of a bank of power half-bridges behind a check of their output pins. When the logic supply becomes good after power-up, it first looks at every output for a short to ground, then at every output for a short to the power rail. Each look lasts a fixed window of clock cycles, set by a parameter that is scaled to the output filter capacitance. The comparator results arrive as flag inputs, one per output for each kind of short. While the test runs, the active-low shutdown line is held low and every half-bridge is held in high impedance.

When a short is seen, the sequencer parks in a holding state. It keeps all outputs in high impedance until every flag has cleared, then runs the test again from the ground phase. After both phases pass, it emits a single-cycle startup strobe that hands control to the normal startup path. From then on, the device reset input only controls the high-impedance enables. Neither a reset nor a later short re-runs the test. Only loss of the supply-good signal re-arms the test. In single-ended output mode the test is skipped and the strobe follows at once.

States: IDLE (waiting for supply), TEST_GND (ground phase), TEST_SUPPLY (rail phase), HOLD_SHORT (short present), PASS (released). Transitions: IDLE→TEST_GND on supply good in a bridge mode; IDLE→PASS on supply good in single-ended mode; TEST_GND→TEST_SUPPLY when the window ends clean; TEST_SUPPLY→PASS when the window ends clean; TEST_GND/TEST_SUPPLY→HOLD_SHORT on a flag of that phase; HOLD_SHORT→TEST_GND when all flags are clear; any state→IDLE on supply loss.

Top module: `short_probe_seq`

## Requirements
- R1: After power-on reset, the block sits in IDLE with `shdn_n` high, every `hiz_en` bit 1 and `startup_go` 0.
- R2: In bridge mode (`out_mode` 2'b00) or parallel bridge mode (2'b01) with no shorts, `startup_go` pulses for exactly one cycle, observed on the clock edge 2*PHASE_CYCLES+1 edges after `supply_ok` is raised.
- R3: `shdn_n` is low on every cycle from the start of the test until the cycle in which `startup_go` is high, and all `hiz_en` bits are 1 while it is low.
- R4: Flags pass through a two-flop synchronizer. A ground flag seen during the ground phase moves the sequencer to HOLD_SHORT, with `shdn_n` low and all outputs in high impedance.
- R5: Rail-short flags are only judged during the rail phase. A rail flag that is present only during the ground phase does not delay `startup_go`.
- R6: In HOLD_SHORT the sequencer stays put while any synchronized flag is set. Once all flags are clear it restarts the ground phase, so `startup_go` follows 2*PHASE_CYCLES+3 edges after the flags fall.
- R7: Changes on `dev_rst_n` during the test alter neither `shdn_n`, `hiz_en` nor the timing of `startup_go`.
- R8: After PASS, `hiz_en` equals all bits of NOT `dev_rst_n`. A later reset pulse or short never brings `shdn_n` low or re-issues `startup_go`.
- R9: In single-ended mode (`out_mode` 2'b10), the test is skipped. `startup_go` is seen one edge after `supply_ok` rises and `shdn_n` never goes low.
- R10: Loss of `supply_ok` returns the block to IDLE and clears the passed status, so the next rise of `supply_ok` runs the full test again.
- R11: A ground flag that reaches the synchronizer output in the last cycle of the ground window wins over the window end and sends the sequencer to HOLD_SHORT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Logic supply good |
| out_mode | input | 2 | Output mode: 00 bridge, 01 parallel bridge, 10 single-ended |
| gnd_short | input | NUM_HB | Per-output short-to-ground comparator flags |
| vdd_short | input | NUM_HB | Per-output short-to-rail comparator flags |
| dev_rst_n | input | 1 | Device reset, active low; honoured only after PASS |
| hiz_en | output | NUM_HB | Per-half-bridge high-impedance enable |
| shdn_n | output | 1 | Shutdown/fault line, active low |
| startup_go | output | 1 | One-cycle strobe handing over to normal startup |

## Verification
The end of a phase window and the arrival of a short flag can fall in the same cycle. The bench provokes this by raising a ground flag so that it leaves the synchronizer exactly on the last ground-window cycle. It judges the result by the absence of `startup_go` and by the strobe arriving the hold-release latency after the flag is dropped. A second overlap is a device reset toggled during the test: the outputs and the strobe cycle must be those of an undisturbed run.

// File: rtl/short_probe_pkg.sv
package short_probe_pkg;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_TEST_GND,
        SP_TEST_SUPPLY,
        SP_HOLD_SHORT,
        SP_PASS
    } sp_state_e;

    localparam logic [1:0] MODE_BRIDGE     = 2'b00;
    localparam logic [1:0] MODE_PAR_BRIDGE = 2'b01;
    localparam logic [1:0] MODE_SINGLE     = 2'b10;

endpackage

// File: rtl/short_probe_sync.sv
module short_probe_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/short_probe_timer.sv
module short_probe_timer #(
    parameter int PHASE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);

    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clear)           cnt_q <= '0;
        else if (run && !last)    cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/short_probe_seq.sv
module short_probe_seq
    import short_probe_pkg::*;
#(
    parameter int NUM_HB       = 4,
    parameter int PHASE_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              supply_ok,
    input  logic [1:0]        out_mode,
    input  logic [NUM_HB-1:0] gnd_short,
    input  logic [NUM_HB-1:0] vdd_short,
    input  logic              dev_rst_n,
    output logic [NUM_HB-1:0] hiz_en,
    output logic              shdn_n,
    output logic              startup_go
);

    localparam int FLAG_W = 2 * NUM_HB;

    sp_state_e         state_q, state_d;
    logic [FLAG_W-1:0] flags_raw, flags_s;
    logic [NUM_HB-1:0] gnd_s, vdd_s;
    logic              gnd_hit, vdd_hit, flag_hit;
    logic              phase_last, timer_clr, timer_run;
    logic              done_q, go_q;

    // comparator flags enter through one shared synchronizer
    assign flags_raw = {vdd_short, gnd_short};

    short_probe_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) flag_sync_i (
        .clk   (clk),
        .rst_n (por_n),
        .d_in  (flags_raw),
        .d_out (flags_s)
    );

    assign gnd_s    = flags_s[NUM_HB-1:0];
    assign vdd_s    = flags_s[FLAG_W-1:NUM_HB];
    assign gnd_hit  = |gnd_s;
    assign vdd_hit  = |vdd_s;
    assign flag_hit = gnd_hit | vdd_hit;

    assign timer_run = (state_q == SP_TEST_GND) || (state_q == SP_TEST_SUPPLY);
    assign timer_clr = (state_d != state_q);

    short_probe_timer #(
        .PHASE_CYCLES (PHASE_CYCLES)
    ) phase_timer_i (
        .clk   (clk),
        .rst_n (por_n),
        .clear (timer_clr),
        .run   (timer_run),
        .last  (phase_last)
    );

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= SP_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SP_IDLE: begin
                if (supply_ok && !done_q) begin
                    if (out_mode == MODE_SINGLE) state_d = SP_PASS;
                    else                         state_d = SP_TEST_GND;
                end
            end
            SP_TEST_GND: begin
                if (!supply_ok)      state_d = SP_IDLE;
                else if (gnd_hit)    state_d = SP_HOLD_SHORT;
                else if (phase_last) state_d = SP_TEST_SUPPLY;
            end
            SP_TEST_SUPPLY: begin
                if (!supply_ok)      state_d = SP_IDLE;
                else if (vdd_hit)    state_d = SP_HOLD_SHORT;
                else if (phase_last) state_d = SP_PASS;
            end
            SP_HOLD_SHORT: begin
                if (!supply_ok)      state_d = SP_IDLE;
                else if (!flag_hit)  state_d = SP_TEST_GND;
            end
            SP_PASS: begin
                if (!supply_ok)      state_d = SP_IDLE;
            end
            default:                 state_d = SP_IDLE;
        endcase
    end

    // passed status and handover strobe
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            done_q <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            go_q <= (state_q != SP_PASS) && (state_d == SP_PASS);
            if (!supply_ok)                 done_q <= 1'b0;
            else if (state_d == SP_PASS)    done_q <= 1'b1;
        end
    end

    // output decode
    always_comb begin
        hiz_en = '1;
        shdn_n = 1'b1;
        unique case (state_q)
            SP_IDLE:        shdn_n = 1'b1;
            SP_TEST_GND,
            SP_TEST_SUPPLY,
            SP_HOLD_SHORT:  shdn_n = 1'b0;
            SP_PASS:        hiz_en = {NUM_HB{~dev_rst_n}};
            default:        shdn_n = 1'b1;
        endcase
    end

    assign startup_go = go_q;

endmodule

// File: rtl/short_probe_chk.sv
module short_probe_chk
    import short_probe_pkg::*;
#(
    parameter int NUM_HB = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              supply_ok,
    input logic [NUM_HB-1:0] hiz_en,
    input logic              shdn_n,
    input logic              startup_go,
    input sp_state_e         state_q,
    input logic              flag_hit
);

    // R3
    hiz_while_testing_chk: assert property (@(posedge clk) disable iff (!por_n)
        !shdn_n |-> (&hiz_en));

    // R2
    go_single_cycle_chk: assert property (@(posedge clk) disable iff (!por_n)
        startup_go |=> !startup_go);

    // R10
    go_needs_supply_chk: assert property (@(posedge clk) disable iff (!por_n)
        startup_go |-> $past(supply_ok));

    // R8
    no_retest_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == SP_PASS && supply_ok) |=> shdn_n);

    // R6
    hold_sticks_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == SP_HOLD_SHORT && supply_ok && flag_hit) |=> (state_q == SP_HOLD_SHORT));

endmodule

bind short_probe_seq short_probe_chk #(.NUM_HB(NUM_HB)) chk_i (
    .clk        (clk),
    .por_n      (por_n),
    .supply_ok  (supply_ok),
    .hiz_en     (hiz_en),
    .shdn_n     (shdn_n),
    .startup_go (startup_go),
    .state_q    (state_q),
    .flag_hit   (flag_hit)
);

// File: tb/short_probe_seq_tb.sv
module short_probe_seq_tb_top;

    localparam int NHB   = 4;
    localparam int PHASE = 16;
    localparam int NOM   = 2 * PHASE + 1;

    logic           clk = 1'b0;
    logic           por_n;
    logic           supply_ok;
    logic [1:0]     out_mode;
    logic [NHB-1:0] gnd_short;
    logic [NHB-1:0] vdd_short;
    logic           dev_rst_n;
    logic [NHB-1:0] hiz_en;
    logic           shdn_n;
    logic           startup_go;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    short_probe_seq #(.NUM_HB(NHB), .PHASE_CYCLES(PHASE)) dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .supply_ok  (supply_ok),
        .out_mode   (out_mode),
        .gnd_short  (gnd_short),
        .vdd_short  (vdd_short),
        .dev_rst_n  (dev_rst_n),
        .hiz_en     (hiz_en),
        .shdn_n     (shdn_n),
        .startup_go (startup_go)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // counts edges until startup_go is seen, and cycles with shdn_n low before it
    task automatic wait_go(input int limit, output int n, output int lows);
        n = 0;
        lows = 0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (startup_go) break;
            if (!shdn_n) lows++;
        end
    endtask

    task automatic power_down();
        supply_ok = 1'b0;
        step(3);
    endtask

    task automatic t_reset();
        check(shdn_n == 1'b1, "R1 shdn_n", shdn_n, 1);
        check(hiz_en == '1, "R1 hiz_en", hiz_en, 15);
        check(startup_go == 1'b0, "R1 startup_go", startup_go, 0);
    endtask

    task automatic t_clean(input logic [1:0] mode);
        int n, lows;
        out_mode  = mode;
        supply_ok = 1'b1;
        wait_go(200, n, lows);
        check(n == NOM, "R2 go latency", n, NOM);
        check(lows == NOM - 1, "R3 shdn low cycles", lows, NOM - 1);
        step(1);
        check(startup_go == 1'b0, "R2 go one cycle", startup_go, 0);
        check(shdn_n == 1'b1, "R2 released", shdn_n, 1);
    endtask

    task automatic t_late_vdd_pulse();
        int n, lows;
        out_mode  = 2'b00;
        supply_ok = 1'b1;
        step(2);
        vdd_short = 4'b0100;
        step(5);
        vdd_short = '0;
        wait_go(200, n, lows);
        check(n + 7 == NOM, "R5 rail flag ignored in ground phase", n + 7, NOM);
    endtask

    task automatic t_gnd_hold();
        int n, lows;
        out_mode  = 2'b01;
        supply_ok = 1'b1;
        step(4);
        gnd_short = 4'b0010;
        step(4);
        check(shdn_n == 1'b0, "R4 shdn low in hold", shdn_n, 0);
        check(hiz_en == '1, "R4 hiz in hold", hiz_en, 15);
        wait_go(60, n, lows);
        check(n == 60, "R6 no go while short", n, 60);
        check(shdn_n == 1'b0, "R6 still held", shdn_n, 0);
        gnd_short = '0;
        wait_go(200, n, lows);
        check(n == NOM + 2, "R6 restart latency", n, NOM + 2);
    endtask

    task automatic t_edge_collision();
        int n, lows;
        out_mode  = 2'b00;
        supply_ok = 1'b1;
        step(14);
        gnd_short = 4'b1000;
        step(10);
        check(shdn_n == 1'b0, "R11 flag wins over window end", shdn_n, 0);
        gnd_short = '0;
        wait_go(200, n, lows);
        check(n == NOM + 2, "R11 go after hold release", n, NOM + 2);
    endtask

    task automatic t_reset_ignored();
        int n, lows;
        out_mode  = 2'b00;
        supply_ok = 1'b1;
        step(3);
        dev_rst_n = 1'b0;
        step(1);
        check(hiz_en == '1, "R7 hiz during test", hiz_en, 15);
        check(shdn_n == 1'b0, "R7 shdn during test", shdn_n, 0);
        step(2);
        dev_rst_n = 1'b1;
        step(3);
        dev_rst_n = 1'b0;
        step(2);
        dev_rst_n = 1'b1;
        wait_go(200, n, lows);
        check(n + 11 == NOM, "R7 go timing unchanged", n + 11, NOM);
    endtask

    task automatic t_after_pass();
        int n, lows;
        check(hiz_en == '0, "R8 switching enabled", hiz_en, 0);
        dev_rst_n = 1'b0;
        #1;
        check(hiz_en == '1, "R8 reset forces hiz", hiz_en, 15);
        gnd_short = 4'b0001;
        vdd_short = 4'b1000;
        wait_go(40, n, lows);
        check(n == 40, "R8 no second go", n, 40);
        check(lows == 0, "R8 shdn stays high", lows, 0);
        dev_rst_n = 1'b1;
        #1;
        check(hiz_en == '0, "R8 release reset", hiz_en, 0);
        gnd_short = '0;
        vdd_short = '0;
        step(3);
    endtask

    task automatic t_single_ended();
        int n, lows;
        out_mode  = 2'b10;
        supply_ok = 1'b1;
        wait_go(200, n, lows);
        check(n == 1, "R9 bypass latency", n, 1);
        check(lows == 0, "R9 no shutdown", lows, 0);
    endtask

    task automatic t_repower();
        supply_ok = 1'b0;
        step(1);
        check(shdn_n == 1'b1, "R10 idle shdn", shdn_n, 1);
        check(hiz_en == '1, "R10 idle hiz", hiz_en, 15);
        supply_ok = 1'b1;
        out_mode  = 2'b00;
        step(1);
        check(shdn_n == 1'b0, "R10 retest starts", shdn_n, 0);
        power_down();
        t_clean(2'b00);
    endtask

    initial begin
        por_n     = 1'b0;
        supply_ok = 1'b0;
        out_mode  = 2'b00;
        gnd_short = '0;
        vdd_short = '0;
        dev_rst_n = 1'b1;
        step(3);
        por_n = 1'b1;
        step(1);
        t_reset();
        t_clean(2'b00);
        t_after_pass();
        t_repower();
        power_down();
        t_clean(2'b01);
        power_down();
        t_late_vdd_pulse();
        power_down();
        t_gnd_hold();
        power_down();
        t_edge_collision();
        power_down();
        t_reset_ignored();
        power_down();
        t_single_ended();
        power_down();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule